// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads page-table entries from memory one word at a time. A caller presents a linear address on a valid/ready request port. The walker then takes a snapshot of the directory base and of the large-page enable. It reads the directory entry. Depending on that entry, it either finishes at once or reads a second-level table entry. It then holds the result, or a fault, on the response port until the caller takes it.

Each entry marks itself present in bit 0. A directory entry may also carry a page-size flag in bit 7. That flag takes effect only while the large-page enable is set. In that case the directory entry maps a 4 MiB region directly, and the walk skips the second read. Every memory read is a request held with a stable address until the memory answers with a read-valid strobe. Any number of wait cycles is allowed.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, while `rsp_valid` and `mem_rd_req` are both 0.
- R2: A request is taken only while idle. `req_ready` stays 0 for the whole time a memory read or a response is pending.
- R3: The first read goes to the word address {dir_base[31:12], laddr[31:22], 2'b00}. `dir_base` and `large_en` are sampled in the cycle the request is taken, and later changes do not affect that walk. Every read address is word aligned.
- R4: For a present directory entry that is not a large-page hit, the second read goes to {pde[31:12], laddr[21:12], 2'b00}.
- R5: A present table entry gives `rsp_paddr` = {pte[31:12], laddr[11:0]} with `rsp_fault` = 0.
- R6: A directory entry with bit 0 = 0 gives `rsp_fault` = 1 and `rsp_paddr` = 0 after exactly one read, even if its bit 7 is set.
- R7: A table entry with bit 0 = 0 gives `rsp_fault` = 1 and `rsp_paddr` = 0 after exactly two reads.
- R8: With `large_en` = 1, a present directory entry with bit 7 = 1 gives `rsp_paddr` = {pde[31:22], laddr[21:0]} after exactly one read.
- R9: With `large_en` = 0, bit 7 of a directory entry has no effect, and the walk reads the second level as in R4.
- R10: `mem_rd_req` and `mem_rd_addr` stay stable until `mem_rd_valid` arrives, whatever the memory latency.
- R11: `rsp_valid`, `rsp_paddr` and `rsp_fault` stay stable until `rsp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_laddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Result held for the caller |
| rsp_ready | input | 1 | Caller takes the result |
| rsp_paddr | output | 32 | Translated physical address, 0 on fault |
| rsp_fault | output | 1 | Page fault: an entry was not present |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry word |
| mem_rd_valid | input | 1 | Memory read data is valid this cycle |
| mem_rd_data | input | 32 | Entry word read from memory |
| dir_base | input | 32 | Page-directory base, bits 31:12 used |
| large_en | input | 1 | Enables 4 MiB mapping by the page-size flag |

## Verification
The bench builds the walker with its default parameters: 10-bit indices, 12-bit offsets, 32-bit entries, present flag in bit 0, page-size flag in bit 7, and large-page support generated in. These values reach both ends of a walk: the one-read large-page path and the two-read small-page path. They also reach faults at each level and the all-ones index corner. A sparse memory image is read with latencies of 0, 3 and 7 cycles, and the response is held back for up to 2 cycles. This exercises the stability rules on both handshakes.

// File: rtl/pw_pkg.sv
package pw_pkg;
   typedef enum logic [1:0] {
      PW_IDLE     = 2'd0,
      PW_READ_PDE = 2'd1,
      PW_READ_PTE = 2'd2,
      PW_DONE     = 2'd3
   } pw_state_e;
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int IDX_W   = 10,
   parameter int ENTRY_W = 32
) (
   input  logic [PA_W-OFF_W-1:0] frame,
   input  logic [IDX_W-1:0]      index,
   output logic [PA_W-1:0]       addr
);
   localparam int ALIGN_W = $clog2(ENTRY_W / 8);

   always_comb begin
      addr = {frame, index, {ALIGN_W{1'b0}}};
   end
endmodule

// File: rtl/pw_phys_compose.sv
module pw_phys_compose #(
   parameter int LA_W        = 32,
   parameter int PA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 10,
   parameter int ENTRY_W     = 32,
   parameter bit LARGE_PAGES = 1'b1
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [LA_W-1:0]    laddr,
   input  logic               large_sel,
   output logic [PA_W-1:0]    paddr
);
   localparam int LOFF_W = OFF_W + IDX_W;

   logic [PA_W-1:0] small_pa;
   assign small_pa = {entry[ENTRY_W-1:OFF_W], laddr[OFF_W-1:0]};

   generate
      if (LARGE_PAGES) begin : g_large
         logic [PA_W-1:0] large_pa;
         assign large_pa = {entry[ENTRY_W-1:LOFF_W], laddr[LOFF_W-1:0]};
         assign paddr    = large_sel ? large_pa : small_pa;
      end else begin : g_small_only
         logic unused_sel;
         assign unused_sel = large_sel;
         assign paddr      = small_pa;
      end
   endgenerate
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
   import pw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      rsp_ready,
   input  logic      mem_rd_valid,
   input  logic      entry_present,
   input  logic      entry_large,
   output pw_state_e state,
   output logic      accept,
   output logic      pde_take,
   output logic      finish
);
   pw_state_e state_q, state_d;

   assign state    = state_q;
   assign accept   = (state_q == PW_IDLE) && req_valid;
   assign pde_take = (state_q == PW_READ_PDE) && mem_rd_valid;
   assign finish   = mem_rd_valid &&
                     ((state_q == PW_READ_PTE) ||
                      ((state_q == PW_READ_PDE) && (!entry_present || entry_large)));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PW_IDLE:     if (req_valid) state_d = PW_READ_PDE;
         PW_READ_PDE: if (mem_rd_valid) state_d = finish ? PW_DONE : PW_READ_PTE;
         PW_READ_PTE: if (mem_rd_valid) state_d = PW_DONE;
         PW_DONE:     if (rsp_ready) state_d = PW_IDLE;
         default:     state_d = PW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PW_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pw_pkg::*;
#(
   parameter int LA_W        = 32,
   parameter int PA_W        = 32,
   parameter int ENTRY_W     = 32,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 10,
   parameter int PRESENT_BIT = 0,
   parameter int LARGE_BIT   = 7,
   parameter bit LARGE_PAGES = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [LA_W-1:0]    req_laddr,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic               rsp_fault,
   output logic               mem_rd_req,
   output logic [PA_W-1:0]    mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [ENTRY_W-1:0] mem_rd_data,
   input  logic [PA_W-1:0]    dir_base,
   input  logic               large_en
);
   localparam int FRAME_W = PA_W - OFF_W;
   localparam int ALIGN_W = $clog2(ENTRY_W / 8);
   localparam int HI_LO   = OFF_W + IDX_W;

   generate
      if (LA_W != 2 * IDX_W + OFF_W) begin : g_bad_la
         $error("LA_W must equal two indices plus the page offset");
      end
      if (FRAME_W + IDX_W + ALIGN_W != PA_W) begin : g_bad_pa
         $error("frame, index and alignment must fill PA_W");
      end
      if (ENTRY_W != PA_W) begin : g_bad_entry
         $error("ENTRY_W must equal PA_W");
      end
      if (PRESENT_BIT >= OFF_W || LARGE_BIT >= OFF_W || PRESENT_BIT == LARGE_BIT) begin : g_bad_flags
         $error("flag bits must be distinct and below the frame field");
      end
   endgenerate

   pw_state_e          state;
   logic               accept, pde_take, finish;
   logic [LA_W-1:0]    la_q;
   logic [FRAME_W-1:0] base_q;
   logic [FRAME_W-1:0] pde_frame_q;
   logic               large_en_q;
   logic               entry_present, entry_large;
   logic [PA_W-1:0]    pde_addr, pte_addr, composed;
   logic [PA_W-1:0]    paddr_q;
   logic               fault_q;

   assign entry_present = mem_rd_data[PRESENT_BIT];

   generate
      if (LARGE_PAGES) begin : g_large_hit
         assign entry_large = large_en_q && mem_rd_data[LARGE_BIT];
      end else begin : g_no_large
         logic unused_large;
         assign unused_large = large_en_q ^ mem_rd_data[LARGE_BIT];
         assign entry_large  = 1'b0;
      end
   endgenerate

   pw_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .rsp_ready     (rsp_ready),
      .mem_rd_valid  (mem_rd_valid),
      .entry_present (entry_present),
      .entry_large   (entry_large),
      .state         (state),
      .accept        (accept),
      .pde_take      (pde_take),
      .finish        (finish)
   );

   pw_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_pde_addr (
      .frame (base_q),
      .index (la_q[LA_W-1:HI_LO]),
      .addr  (pde_addr)
   );

   pw_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_pte_addr (
      .frame (pde_frame_q),
      .index (la_q[HI_LO-1:OFF_W]),
      .addr  (pte_addr)
   );

   pw_phys_compose #(
      .LA_W(LA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
      .ENTRY_W(ENTRY_W), .LARGE_PAGES(LARGE_PAGES)
   ) u_compose (
      .entry     (mem_rd_data),
      .laddr     (la_q),
      .large_sel (state == PW_READ_PDE),
      .paddr     (composed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         la_q        <= '0;
         base_q      <= '0;
         large_en_q  <= 1'b0;
         pde_frame_q <= '0;
         paddr_q     <= '0;
         fault_q     <= 1'b0;
      end else begin
         if (accept) begin
            la_q       <= req_laddr;
            base_q     <= dir_base[PA_W-1:OFF_W];
            large_en_q <= large_en;
         end
         if (pde_take) begin
            pde_frame_q <= mem_rd_data[ENTRY_W-1:OFF_W];
         end
         if (finish) begin
            fault_q <= !entry_present;
            paddr_q <= entry_present ? composed : '0;
         end
      end
   end

   logic unused_base;
   assign unused_base = ^dir_base[OFF_W-1:0];

   assign req_ready   = (state == PW_IDLE);
   assign mem_rd_req  = (state == PW_READ_PDE) || (state == PW_READ_PTE);
   assign mem_rd_addr = (state == PW_READ_PDE) ? pde_addr : pte_addr;
   assign rsp_valid   = (state == PW_DONE);
   assign rsp_paddr   = paddr_q;
   assign rsp_fault   = fault_q;
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
   parameter int LA_W        = 32,
   parameter int PA_W        = 32,
   parameter int ENTRY_W     = 32,
   parameter int PRESENT_BIT = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               rsp_valid,
   input logic               rsp_ready,
   input logic [PA_W-1:0]    rsp_paddr,
   input logic               rsp_fault,
   input logic               mem_rd_req,
   input logic [PA_W-1:0]    mem_rd_addr,
   input logic               mem_rd_valid,
   input logic [ENTRY_W-1:0] mem_rd_data
);
   localparam int ALIGN_W = $clog2(ENTRY_W / 8);

   assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && (mem_rd_req || rsp_valid)));

   assert_read_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (mem_rd_addr[ALIGN_W-1:0] == '0));

   assert_stop_after_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rd_valid && !mem_rd_data[PRESENT_BIT]) |=> !mem_rd_req);

   assert_fault_zero_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

   assert_read_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

   assert_rsp_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
endmodule

bind pt_walker pw_walker_chk #(
   .LA_W(LA_W), .PA_W(PA_W), .ENTRY_W(ENTRY_W), .PRESENT_BIT(PRESENT_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .rsp_ready    (rsp_ready),
   .rsp_paddr    (rsp_paddr),
   .rsp_fault    (rsp_fault),
   .mem_rd_req   (mem_rd_req),
   .mem_rd_addr  (mem_rd_addr),
   .mem_rd_valid (mem_rd_valid),
   .mem_rd_data  (mem_rd_data)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_laddr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic [31:0] dir_base = '0;
   logic        large_en = 1'b0;

   always #2.5 clk = ~clk;

   pt_walker u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .dir_base(dir_base), .large_en(large_en)
   );

   typedef struct {
      logic [31:0] paddr;
      logic        fault;
      int          nrd;
      logic [31:0] rd0;
      logic [31:0] rd1;
      string       tag;
   } exp_t;

   logic [31:0] mem_img [logic [31:0]];
   exp_t        sb_q[$];
   logic [31:0] rd_log[$];
   int          tests = 0;
   int          fails = 0;
   int          mem_lat = 0;
   int          rsp_stall = 0;
   int          wcnt = 0;
   int          scnt = 0;
   bit          seen = 0;
   bit          unstable = 0;
   bit          busy_bad = 0;
   logic [31:0] hold_p;
   logic        hold_f;

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem_img.exists(a) ? mem_img[a] : 32'h0;
   endfunction

   function automatic exp_t model(input logic [31:0] la, input logic [31:0] base,
                                  input logic le, input string tag);
      exp_t e;
      logic [31:0] pde, pte;
      e.tag = tag; e.nrd = 1; e.rd1 = '0; e.fault = 1'b0; e.paddr = '0;
      e.rd0 = {base[31:12], la[31:22], 2'b00};
      pde = rd(e.rd0);
      if (!pde[0]) e.fault = 1'b1;
      else if (le && pde[7]) e.paddr = {pde[31:22], la[21:0]};
      else begin
         e.nrd = 2;
         e.rd1 = {pde[31:12], la[21:12], 2'b00};
         pte = rd(e.rd1);
         if (!pte[0]) e.fault = 1'b1;
         else e.paddr = {pte[31:12], la[11:0]};
      end
      return e;
   endfunction

   task automatic check(input bit ok, input string msg);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s", msg);
      end
   endtask

   // memory model
   always @(negedge clk) begin
      if (mem_rd_valid) begin
         mem_rd_valid = 1'b0;
         wcnt = 0;
      end else if (rst_n && mem_rd_req) begin
         if (wcnt >= mem_lat) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = rd(mem_rd_addr);
            rd_log.push_back(mem_rd_addr);
         end else begin
            wcnt++;
         end
      end
   end

   // response monitor and scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (req_ready && (mem_rd_req || rsp_valid)) busy_bad = 1'b1;
         if (rsp_valid && !rsp_ready) begin
            if (!seen) begin
               seen = 1'b1; hold_p = rsp_paddr; hold_f = rsp_fault;
            end else if (rsp_paddr != hold_p || rsp_fault != hold_f) begin
               unstable = 1'b1;
            end
            if (scnt >= rsp_stall) begin
               exp_t e;
               if (sb_q.size() == 0) begin
                  check(1'b0, "R2 response with no request outstanding");
               end else begin
                  e = sb_q.pop_front();
                  check(rsp_paddr == e.paddr && rsp_fault == e.fault,
                        $sformatf("%s result: got paddr=%h fault=%0b, expected paddr=%h fault=%0b",
                                  e.tag, rsp_paddr, rsp_fault, e.paddr, e.fault));
                  check(rd_log.size() == e.nrd && rd_log[0] == e.rd0 &&
                        (e.nrd < 2 || rd_log[1] == e.rd1),
                        $sformatf("R3/R4 reads (%s): got n=%0d a0=%h a1=%h, expected n=%0d a0=%h a1=%h",
                                  e.tag, rd_log.size(),
                                  rd_log.size() > 0 ? rd_log[0] : 32'h0,
                                  rd_log.size() > 1 ? rd_log[1] : 32'h0,
                                  e.nrd, e.rd0, e.rd1));
                  check(!busy_bad, $sformatf("R2 ready while busy: got 1, expected 0 (%s)", e.tag));
                  if (rsp_stall > 0 || mem_lat > 0)
                     check(!unstable, $sformatf("R11/R10 held response moved: got 1, expected 0 (%s)", e.tag));
               end
               rd_log.delete();
               rsp_ready = 1'b1;
               scnt = 0; seen = 1'b0; unstable = 1'b0; busy_bad = 1'b0;
            end else begin
               scnt++;
            end
         end else begin
            rsp_ready = 1'b0;
         end
      end
   end

   task automatic translate(input logic [31:0] la, input logic [31:0] base,
                            input logic le, input string tag);
      do @(negedge clk); while (!req_ready);
      sb_q.push_back(model(la, base, le, tag));
      req_laddr = la; dir_base = base; large_en = le; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; dir_base = ~base; large_en = ~le; req_laddr = ~la;
      while (sb_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // directory at 0x10000
      mem_img[32'h0001_0004] = 32'h0002_0001; // idx 1 -> table 0x20000
      mem_img[32'h0002_000C] = 32'hABCD_E001; // pte idx 3
      mem_img[32'h0002_0010] = 32'hFFFF_F000; // pte idx 4 not present
      mem_img[32'h0001_0008] = 32'h1240_0081; // idx 2 large flag, present
      mem_img[32'h1240_0000] = 32'h5555_5003; // used when flag ignored
      mem_img[32'h0001_0010] = 32'h0840_0080; // idx 4 flag set, not present
      // directory at 0x30000
      mem_img[32'h0003_0FFC] = 32'h0004_0003;
      mem_img[32'h0004_0FFC] = 32'h7777_7001;

      repeat (3) @(negedge clk);
      check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_req == 1'b0,
            $sformatf("R1 reset: got ready=%0b rsp=%0b req=%0b, expected 1 0 0",
                      req_ready, rsp_valid, mem_rd_req));
      rst_n = 1'b1;

      for (int pass = 0; pass < 3; pass++) begin
         mem_lat   = (pass == 0) ? 0 : (pass == 1) ? 3 : 7;
         rsp_stall = (pass == 0) ? 0 : (pass == 1) ? 2 : 1;
         translate(32'h0040_3123, 32'h0001_0000, 1'b0, "R5 small page");
         translate(32'h0040_3123, 32'h0001_0000, 1'b1, "R5 small page, large_en");
         translate(32'h0080_0456, 32'h0001_0000, 1'b1, "R8 large page");
         translate(32'h0080_0456, 32'h0001_0000, 1'b0, "R9 flag ignored");
         translate(32'h00C0_0000, 32'h0001_0000, 1'b1, "R6 absent pde");
         translate(32'h0100_0ABC, 32'h0001_0000, 1'b1, "R6 absent pde with flag");
         translate(32'h0040_4000, 32'h0001_0000, 1'b0, "R7 absent pte");
         translate(32'hFFFF_FFFF, 32'h0003_0000, 1'b1, "R3 base and top index");
      end

      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule